// File: doc/BRIEF.md
# Transceiver Power-Down Controller

This synchronous controller decides when a multi-channel serial line transceiver drives or tri-states its line drivers and its receiver outputs. It resynchronises every control pin, every digitised "valid line level" flag and every monitored data line into its own clock domain. It then applies three power-down rules in a fixed order. The first is a manual shutdown pin. The second is a manual keep-awake pin. The third is an automatic rule. In basic mode the automatic rule judges activity by the line levels. In enhanced mode it judges activity by data edges and an idle timeout.

A level-status output, `invalid_no`, reports whether any receiver sees a valid line level. It does so in every mode, so it can be wired back to the two control pins to build an automatic power-down outside the block. An auxiliary receiver enable is asserted at all times. A supply-generator enable follows the transmitter enable, so the charge supply runs only while the drivers are in use.

The mode is chosen by the `MODE` parameter. The idle timeout is `CLK_HZ * IDLE_SEC` clock cycles, and the default is a 30-second window.

Top module: `xcvr_pwr_ctrl`

## Requirements
- R1: While the synchronised `force_off_ni` is low, `tx_oe_o` and `pump_en_o` are 0, whatever `force_on_i`, the line levels, the data edges or the timer state. `pump_en_o` equals `tx_oe_o` at all times.
- R2: With `force_off_ni` high and `force_on_i` high, `tx_oe_o` is 1 in both modes, even after the idle timer has expired.
- R3: `invalid_no` is 1 when at least one bit of `lvl_ok_i` is 1, and 0 when all bits are 0. This holds in every mode, including manual shutdown.
- R4: In basic mode (`MODE=APD_LEVEL`), with `force_off_ni` high and `force_on_i` low, `tx_oe_o` equals the OR of `lvl_ok_i`. Data edges have no effect on it.
- R5: In enhanced mode (`MODE=APD_EDGE`), with `force_off_ni` high and `force_on_i` low, `tx_oe_o` falls once no edge has been seen on any `tx_data_i` or `rx_data_i` bit for `CLK_HZ*IDLE_SEC` cycles. An input toggle keeps `tx_oe_o` high through the posedge `CLK_HZ*IDLE_SEC+2` after the toggle, and `tx_oe_o` is low after posedge `CLK_HZ*IDLE_SEC+3`.
- R6: While `force_off_ni` is low, `rx_oe_o` is 0 and `rx_aux_oe_o` stays 1.
- R7: With `rx_en_ni` high, `rx_oe_o` is 0 in every mode. With `rx_en_ni` low and `force_off_ni` high, `rx_oe_o` is 1.
- R8: In enhanced mode, a rising edge on `force_off_ni` restarts the idle window. `tx_oe_o` is high after posedge `CLK_HZ*IDLE_SEC+1` after the release and low after posedge `CLK_HZ*IDLE_SEC+2`.
- R9: Every input reaches the outputs through exactly two flops. A change driven before posedge 1 shows after posedge 2 and not after posedge 1. An edge that wakes an expired enhanced-mode controller raises `tx_oe_o` after posedge 2.
- R10: During reset, the synchronisers read force-off high, force-on low, receiver enable low, no levels and data low, and the timer is cleared. This gives `rx_oe_o`=1, `invalid_no`=0, and `tx_oe_o`=1 in enhanced mode and 0 in basic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_off_ni | input | 1 | Manual shutdown, active low, highest priority |
| force_on_i | input | 1 | Keep-awake, overrides automatic power-down |
| rx_en_ni | input | 1 | Main receiver output enable, active low |
| lvl_ok_i | input | N_RX | Per-receiver valid line level flag |
| tx_data_i | input | N_TX | Transmitter data lines watched for edges |
| rx_data_i | input | N_RX | Receiver data lines watched for edges |
| tx_oe_o | output | 1 | Transmitter output enable |
| rx_oe_o | output | 1 | Main receiver output enable |
| rx_aux_oe_o | output | 1 | Auxiliary receiver output enable, always 1 |
| pump_en_o | output | 1 | Supply-generator enable |
| invalid_no | output | 1 | Low when no receiver sees a valid level |

## Verification
The bench builds two instances that share every input: `u0` in enhanced mode and `u1` in basic mode. Both use `N_TX=2`, `N_RX=3`, `CLK_HZ=4` and `IDLE_SEC=3`, which gives a 12-cycle idle window. With three control pins and three level flags, all 64 static input combinations can be swept and checked against arithmetic expectations. The short window also brings the exact expiry cycle, the wake-up latency and the restart after force-off within a few dozen cycles.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  typedef enum logic {
    APD_LEVEL = 1'b0,
    APD_EDGE  = 1'b1
  } apd_mode_e;
endpackage

// File: rtl/xpc_sync.sv
module xpc_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/xpc_idle_timer.sv
module xpc_idle_timer #(
  parameter int unsigned NL    = 1,
  parameter int unsigned LIMIT = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] lines_i,
  input  logic          hold_i,
  output logic          act_o,
  output logic          expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [NL-1:0] prev_q;
  logic [CW-1:0] cnt_q;

  assign act_o     = |(lines_i ^ prev_q);
  assign expired_o = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lines_i;
      if (act_o || hold_i) cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + CW'(1);
    end
  end

  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o || hold_i) |=> (cnt_q == '0));
  // R5
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && !hold_i && !expired_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  // R5
  expiry_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !act_o && !hold_i) |=> expired_o);
endmodule

// File: rtl/xcvr_pwr_ctrl.sv
module xcvr_pwr_ctrl #(
  parameter int unsigned        N_TX     = 3,
  parameter int unsigned        N_RX     = 5,
  parameter xpc_pkg::apd_mode_e MODE     = xpc_pkg::APD_EDGE,
  parameter int unsigned        CLK_HZ   = 32_000_000,
  parameter int unsigned        IDLE_SEC = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            force_off_ni,
  input  logic            force_on_i,
  input  logic            rx_en_ni,
  input  logic [N_RX-1:0] lvl_ok_i,
  input  logic [N_TX-1:0] tx_data_i,
  input  logic [N_RX-1:0] rx_data_i,
  output logic            tx_oe_o,
  output logic            rx_oe_o,
  output logic            rx_aux_oe_o,
  output logic            pump_en_o,
  output logic            invalid_no
);
  localparam int unsigned NDATA = N_TX + N_RX;
  localparam int unsigned SW    = 3 + N_RX + NDATA;
  localparam int unsigned LIMIT = CLK_HZ * IDLE_SEC;
  // force-off reads inactive (high) during reset; everything else low
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0]    raw, s;
  logic             s_foff_n, s_fon, s_rxen_n;
  logic [N_RX-1:0]  s_lvl;
  logic [NDATA-1:0] s_data;
  logic             any_lvl, awake;

  assign raw = {force_off_ni, force_on_i, rx_en_ni, lvl_ok_i, tx_data_i, rx_data_i};

  xpc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (s)
  );

  assign s_foff_n = s[SW-1];
  assign s_fon    = s[SW-2];
  assign s_rxen_n = s[SW-3];
  assign s_lvl    = s[NDATA +: N_RX];
  assign s_data   = s[NDATA-1:0];
  assign any_lvl  = |s_lvl;

  if (MODE == xpc_pkg::APD_EDGE) begin : g_edge
    logic act, expired;
    xpc_idle_timer #(.NL(NDATA), .LIMIT(LIMIT)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lines_i   (s_data),
      .hold_i    (!s_foff_n),
      .act_o     (act),
      .expired_o (expired)
    );
    // a fresh edge wakes the drivers in the cycle it is seen
    assign awake = act || !expired;
  end else begin : g_level
    logic unused_data;
    assign unused_data = ^s_data;
    assign awake = any_lvl;
  end

  assign tx_oe_o     = s_foff_n && (s_fon || awake);
  assign pump_en_o   = tx_oe_o;
  assign rx_oe_o     = s_foff_n && !s_rxen_n;
  assign rx_aux_oe_o = 1'b1;
  assign invalid_no  = any_lvl;

  // R1
  force_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_foff_n |-> (!tx_oe_o && !pump_en_o));
  // R2
  force_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_foff_n && s_fon) |-> tx_oe_o);
  // R6
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_foff_n |-> (!rx_oe_o && rx_aux_oe_o));
  // R7
  rx_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rxen_n |-> !rx_oe_o);
endmodule

// File: tb/sim_xcvr_pwr_ctrl.sv
module sim_xcvr_pwr_ctrl;
  localparam int NTX = 2;
  localparam int NRX = 3;
  localparam int HZ  = 4;
  localparam int SEC = 3;
  localparam int L   = HZ * SEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic foff_n = 1'b1, fon = 1'b0, rxen_n = 1'b0;
  logic [NRX-1:0] lvl = '0;
  logic [NTX-1:0] txd = '0;
  logic [NRX-1:0] rxd = '0;
  logic e_tx, e_rx, e_aux, e_pump, e_inv;
  logic b_tx, b_rx, b_aux, b_pump, b_inv;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  xcvr_pwr_ctrl #(.N_TX(NTX), .N_RX(NRX), .MODE(xpc_pkg::APD_EDGE),
                  .CLK_HZ(HZ), .IDLE_SEC(SEC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .force_off_ni(foff_n), .force_on_i(fon),
    .rx_en_ni(rxen_n), .lvl_ok_i(lvl), .tx_data_i(txd), .rx_data_i(rxd),
    .tx_oe_o(e_tx), .rx_oe_o(e_rx), .rx_aux_oe_o(e_aux), .pump_en_o(e_pump),
    .invalid_no(e_inv));

  xcvr_pwr_ctrl #(.N_TX(NTX), .N_RX(NRX), .MODE(xpc_pkg::APD_LEVEL),
                  .CLK_HZ(HZ), .IDLE_SEC(SEC)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .force_off_ni(foff_n), .force_on_i(fon),
    .rx_en_ni(rxen_n), .lvl_ok_i(lvl), .tx_data_i(txd), .rx_data_i(rxd),
    .tx_oe_o(b_tx), .rx_oe_o(b_rx), .rx_aux_oe_o(b_aux), .pump_en_o(b_pump),
    .invalid_no(b_inv));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R10 reset state
    #10;
    chk("R10 enh tx", e_tx, 1'b1);
    chk("R10 bas tx", b_tx, 1'b0);
    chk("R10 rx", e_rx, 1'b1);
    chk("R10 inv", e_inv, 1'b0);
    chk("R10 aux", b_aux, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    ticks(2);

    // R1 R2 R3 R4 R6 R7: full static sweep
    for (int c = 0; c < 64; c++) begin
      logic f_n, o, r_n, al;
      f_n = c[5]; o = c[4]; r_n = c[3];
      lvl = c[2:0];
      foff_n = f_n; fon = o; rxen_n = r_n;
      al = |c[2:0];
      ticks(2);
      chk("R4 bas tx", b_tx, f_n & (o | al));
      chk("R1 bas pump", b_pump, b_tx);
      chk("R1 enh pump", e_pump, e_tx);
      if (!f_n) chk("R1 enh tx", e_tx, 1'b0);
      if (f_n && o) chk("R2 enh tx", e_tx, 1'b1);
      chk("R7 enh rx", e_rx, f_n & ~r_n);
      chk("R7 bas rx", b_rx, f_n & ~r_n);
      chk("R6 aux", e_aux & b_aux, 1'b1);
      chk("R3 enh inv", e_inv, al);
      chk("R3 bas inv", b_inv, al);
    end

    // R4: edges ignored in basic mode
    foff_n = 1'b1; fon = 1'b0; rxen_n = 1'b0; lvl = '0;
    ticks(2);
    for (int k = 0; k < 4; k++) begin
      txd = txd ^ NTX'(k + 1);
      rxd = rxd ^ NRX'(k + 2);
      ticks(2);
      chk("R4 bas tx edge-ignored", b_tx, 1'b0);
    end

    // R5: expiry exactly after L idle cycles
    txd[0] = ~txd[0];
    ticks(L + 2);
    chk("R5 still on", e_tx, 1'b1);
    ticks(1);
    chk("R5 expired", e_tx, 1'b0);
    chk("R1 pump off idle", e_pump, 1'b0);
    // R2: force-on overrides expired timer
    fon = 1'b1;
    ticks(2);
    chk("R2 after expiry", e_tx, 1'b1);
    fon = 1'b0;
    ticks(2);
    chk("R5 off again", e_tx, 1'b0);

    // R9: wake latency
    rxd[2] = ~rxd[2];
    ticks(1);
    chk("R9 not yet", e_tx, 1'b0);
    ticks(1);
    chk("R9 wake", e_tx, 1'b1);

    // R5: repeated edges keep it awake
    for (int k = 0; k < 6; k++) begin
      ticks(L - 2);
      if (k % 2 == 0) txd[1] = ~txd[1]; else rxd[0] = ~rxd[0];
      chk("R5 kept awake", e_tx, 1'b1);
    end

    // R8: force-off release restarts the window
    foff_n = 1'b0; lvl = 3'b010;
    ticks(L + 5);
    chk("R1 off tx", e_tx, 1'b0);
    chk("R3 inv in shutdown", e_inv, 1'b1);
    chk("R6 rx off", e_rx, 1'b0);
    chk("R6 aux on", e_aux, 1'b1);
    foff_n = 1'b1;
    ticks(L + 1);
    chk("R8 on", e_tx, 1'b1);
    ticks(1);
    chk("R8 off", e_tx, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule